// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a watchdog for a small 8-bit microcontroller. Software programs it through one 8-bit control register on a simple register bus: a write strobe with write data, and combinational read data. The time base is a separate free-running oscillator. Its rising edges are synchronised into the system clock domain and divided by a selectable power-of-two prescaler. Each prescaler wrap advances a `CNT_W`-bit up-counter, which is 16 bits by default. When the counter overflows past its all-ones value, the block raises a reset request lasting `RST_PULSE` system clocks.

Software keeps the system alive by writing the restart bit before the counter runs out. A restart zeroes both the counter and the prescaler. The enable bit can only be set by software. Every reset clears it: the external reset and the watchdog's own request both do. A sticky status bit records that the last reset came from the watchdog, so start-up code can tell the two apart.

The oscillator input is treated as asynchronous. To be seen, each high phase and each low phase must last at least two system clocks. The external reset `rst_n` is asynchronous when asserted. The system reset controller is expected to release it in step with `clk`.

Top module: `wdog_timer`

## Requirements
- R1: After an external reset, the control register reads 0x00 and `wdt_rst_req` is low.
- R2: While the enable bit is 0, the counter and the prescaler are held at zero. Oscillator edges then never raise a reset request. After enabling, the first overflow needs the full count.
- R3: The prescaler field N is in bits 2:0 and selects a divide of 2^(N+1). With the block enabled, `wdt_rst_req` rises after exactly 2^CNT_W * 2^(N+1) oscillator rising edges, and not after one edge fewer. It rises on the third system clock edge after the oscillator input goes high.
- R4: Each reset request is one high pulse of exactly `RST_PULSE` system clocks.
- R5: A watchdog reset request clears the enable bit. Further oscillator edges then raise no new request.
- R6: Bit 5 reads 1 once a watchdog reset request has occurred. Register writes and re-enabling leave it set. Only the external reset clears it.
- R7: Writing 1 to bit 6 restarts the count from zero: the next overflow needs the full count again. Bit 6 always reads 0.
- R8: Writing 1 to bit 7 sets the enable bit. Writing 0 to bit 7 has no effect.
- R9: A new prescaler field written while the block is enabled is used only from the next prescaler wrap. The current divide period finishes with the old setting.
- R10: Reads return the enable bit in bit 7 and the watchdog-reset flag in bit 5. Bits 6, 4 and 3 read 0. Bits 2:0 return the last written prescaler field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous assertion |
| osc_tick | input | 1 | Free-running oscillator time base, asynchronous to clk |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| wdt_rst_req | output | 1 | System reset request pulse |

## Verification
Writes are applied for one clock edge. The new register value can be read at the following falling edge. The bench therefore reads back right after each write task returns. An oscillator rising edge reaches the counter on the third system clock edge after it is driven, through two synchroniser stages and then the edge register. The request then rises on that same edge. The bench applies each oscillator edge as a four-clock task, so after the task returns the request must already be high. The bench checks it there, one edge before and one edge after the expected count. A restart takes effect on the second clock edge after its write, before the next oscillator edge can arrive. The pulse length is measured by a monitor that counts request-high cycles at falling edges. The bench reads it only after the pulse has ended.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned CLR_BIT  = 6;
  localparam int unsigned FLAG_BIT = 5;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PSEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        restart,
  input  logic                        tick,
  input  logic [PSEL_W-1:0]           psel_load,
  output logic                        wrap,
  output logic [(1 << PSEL_W)-1:0]    pre_q
);
  localparam int unsigned DIV_W = 1 << PSEL_W;
  localparam logic [PSEL_W-1:0] TOP_SEL = PSEL_W'(DIV_W - 1);

  logic [DIV_W-1:0]  pre_d;
  logic [PSEL_W-1:0] act_q, act_d;
  logic [DIV_W-1:0]  limit;
  logic              at_lim;

  assign limit  = {DIV_W{1'b1}} >> (TOP_SEL - act_q);
  assign at_lim = (pre_q == limit);
  assign wrap   = run & ~restart & tick & at_lim;

  always_comb begin
    pre_d = pre_q;
    act_d = act_q;
    if (!run || restart) begin
      pre_d = '0;
      act_d = psel_load;
    end else if (tick) begin
      if (at_lim) begin
        pre_d = '0;
        act_d = psel_load;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      pre_q <= pre_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             step,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  assign ovf = run & ~restart & step & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart) cnt_d = '0;
    else if (step)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int unsigned RST_PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);
  localparam int unsigned PW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (fire)              left_d = PW'(RST_PULSE);
    else if (left_q != '0) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign req = (left_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PSEL_W      = 3,
  parameter int unsigned RST_PULSE   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wdt_rst_req
);
  localparam int unsigned DIV_W = 1 << PSEL_W;

  logic              en_q, en_d;
  logic              flag_q, flag_d;
  logic              clr_q, clr_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic              run;
  logic              tick_pulse;
  logic              pre_wrap;
  logic              cnt_ovf;
  logic [DIV_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q;

  assign run = en_q & ~wdt_rst_req;

  always_comb begin
    en_d   = en_q;
    flag_d = flag_q | wdt_rst_req;
    psel_d = psel_q;
    clr_d  = 1'b0;
    if (wdt_rst_req) begin
      en_d = 1'b0;
    end else if (reg_we) begin
      if (reg_wdata[EN_BIT]) en_d = 1'b1;
      clr_d  = reg_wdata[CLR_BIT];
      psel_d = reg_wdata[PSEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      clr_q  <= 1'b0;
      psel_q <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      clr_q  <= clr_d;
      psel_q <= psel_d;
    end
  end

  always_comb begin
    reg_rdata               = '0;
    reg_rdata[EN_BIT]       = en_q;
    reg_rdata[FLAG_BIT]     = flag_q;
    reg_rdata[PSEL_W-1:0]   = psel_q;
  end

  wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (osc_tick),
    .rise_pulse (tick_pulse)
  );

  wdog_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .restart   (clr_q),
    .tick      (tick_pulse),
    .psel_load (psel_d),
    .wrap      (pre_wrap),
    .pre_q     (pre_q)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (clr_q),
    .step    (pre_wrap),
    .ovf     (cnt_ovf),
    .cnt_q   (cnt_q)
  );

  wdog_rstgen #(.RST_PULSE(RST_PULSE)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (cnt_ovf),
    .req   (wdt_rst_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned RST_PULSE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [REG_W-1:0] reg_rdata,
  input  logic             wdt_rst_req,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [DIV_W-1:0] pre_q
);
  localparam int unsigned LW = $clog2(RST_PULSE + 2) + 1;

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           len_q <= '0;
    else if (wdt_rst_req) len_q <= len_q + 1'b1;
    else                  len_q <= '0;
  end

  // R2
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[EN_BIT] |=> (cnt_q == '0) && (pre_q == '0));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_req) |-> (len_q == LW'(RST_PULSE)));

  // R5
  self_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |=> !reg_rdata[EN_BIT]);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[FLAG_BIT] |=> reg_rdata[FLAG_BIT]);

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[CLR_BIT] && !wdt_rst_req) |=> ##1 (cnt_q == '0));

  // R8
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[EN_BIT] && !wdt_rst_req) |=> reg_rdata[EN_BIT]);
endmodule

bind wdog_timer wdog_timer_chk #(
  .CNT_W     (CNT_W),
  .DIV_W     (DIV_W),
  .RST_PULSE (RST_PULSE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .wdt_rst_req (wdt_rst_req),
  .cnt_q       (cnt_q),
  .pre_q       (pre_q)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  localparam int CNT_W = 4;
  localparam int PULSE = 16;
  localparam int FULL  = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wdt_rst_req;

  int errors = 0;
  int checks = 0;
  int run_len = 0;
  int last_len = 0;
  int rises = 0;
  logic req_prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CNT_W(CNT_W), .PSEL_W(3), .RST_PULSE(PULSE), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst_req(wdt_rst_req)
  );

  always @(negedge clk) begin
    if (wdt_rst_req) begin
      run_len = run_len + 1;
      if (!req_prev) rises = rises + 1;
    end else if (run_len != 0) begin
      last_len = run_len;
      run_len = 0;
    end
    req_prev = wdt_rst_req;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ext_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rises = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1;
      idle(2);
      osc_tick = 1'b0;
      idle(2);
    end
  endtask

  initial begin
    idle(2);
    ext_reset();
    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 req", wdt_rst_req, 0);

    // R2 disabled: no counting
    ticks(40);
    check("R2 no request while disabled", rises, 0);
    wr(8'h80);
    check("R8 enable set", reg_rdata, 8'h80);
    ticks(FULL * 2 - 1);
    check("R2 full count after enable (one short)", wdt_rst_req, 0);
    ticks(1);
    check("R2 fires at full count", wdt_rst_req, 1);
    idle(PULSE + 4);
    check("R4 pulse length", last_len, PULSE);
    check("R5 enable cleared", reg_rdata[7], 0);
    check("R6 flag set", reg_rdata[5], 1);
    ticks(40);
    check("R5 no further request", rises, 1);
    wr(8'h81);
    check("R6 flag kept on re-enable, R10 layout", reg_rdata, 8'hA1);

    // R1 external reset clears flag
    ext_reset();
    check("R6 external reset clears flag", reg_rdata, 8'h00);

    // R3 sweep of every prescaler setting
    for (int n = 0; n < 8; n++) begin
      int k;
      k = FULL * (2 << n);
      ext_reset();
      wr(8'h80 | 8'(n));
      check("R10 readback", reg_rdata, 8'h80 | n);
      ticks(k - 1);
      check("R3 no request one edge early", wdt_rst_req, 0);
      ticks(1);
      check("R3 request at full count", wdt_rst_req, 1);
      idle(PULSE + 4);
      check("R4 pulse length", last_len, PULSE);
      check("R5 R6 R10 readback after watchdog reset", reg_rdata, 8'h20 | n);
      check("R3 single request", rises, 1);
    end

    // R7 restart and R8 write-0 ignored
    ext_reset();
    wr(8'h80);
    wr(8'h00);
    check("R8 writing 0 keeps enable", reg_rdata, 8'h80);
    ticks(20);
    wr(8'hC0);
    check("R7 restart bit reads 0", reg_rdata[6], 0);
    ticks(FULL * 2 - 1);
    check("R7 restart pushes timeout out", wdt_rst_req, 0);
    ticks(1);
    check("R7 full count after restart", wdt_rst_req, 1);
    idle(PULSE + 4);

    // R9 prescaler change applies at next wrap
    ext_reset();
    wr(8'h80);
    ticks(1);
    wr(8'h82);
    check("R9 new field reads back", reg_rdata, 8'h82);
    ticks(1 + (FULL - 1) * 8 - 1);
    check("R9 no request one edge early", wdt_rst_req, 0);
    ticks(1);
    check("R9 request with deferred divide", wdt_rst_req, 1);
    idle(PULSE + 4);
    check("R9 single request", rises, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule